// File: doc/BRIEF.md
# Trigger-Qualified Timer Counter

This block is an up/down counter clocked by the internal clock, whose counting is qualified by an external trigger according to a programmable three-bit qualification mode. Code 0 lets the counter run freely, code 5 lets it advance only while the trigger level is high, and code 6 holds it until a rising trigger edge and then lets it run. Every other code freezes the counter. The trigger never clocks the counter. It only decides on which internal clock cycles an advance is permitted. The direction always comes from a separate direction pin.

The counter counts between 0 and a programmable reload value. It wraps at either end, and each wrap is flagged by a single-cycle update pulse. Software-style controls are plain pins: a mode write strobe with its data, a mode readback, a global enable, a direction bit, a reload value, and a load strobe that presets the count. The trigger is asynchronous to the clock and passes through a two-stage synchronizer inside the block. There is no streaming data path, so no valid/ready handshake is needed at the edge.

Top module: `trig_timer`

## Requirements
- R1: After reset the count is 0, the mode readback is 0, the update pulse is low and no triggered start is pending.
- R2: Writing the mode (mode_wr high for one cycle) stores any 3-bit code, and mode_rd returns exactly that code from the next cycle on.
- R3: With mode 0 and the enable set, the count advances by one on every clock.
- R4: With mode 5, the count advances only while the synchronized trigger is high. A trigger level sampled at clock edge k governs the advance at edge k+2, and the count holds while the trigger is low.
- R5: With mode 6, counting starts on a rising edge of the synchronized trigger (first advance two edges after the edge that samples the rise). It then continues whatever the trigger level, and further rising edges change nothing.
- R6: Clearing the enable in mode 6 stops counting and rearms the start, so a later rise is needed again once the enable is restored.
- R7: Mode codes other than 0, 5 and 6 hold the count unchanged even with the enable set.
- R8: cfg_dir 0 counts up and 1 counts down, in every mode.
- R9: Counting up from a value at or above the reload value goes to 0. Counting down from 0 goes to the reload value. Each such wrap raises upd_pulse for exactly the one cycle after the wrapping edge.
- R10: With the enable cleared, the count never advances in any mode.
- R11: A load strobe sets the count to the load value at the next edge. It takes priority over any advance or wrap in that cycle and produces no update pulse.
- R12: Any mode write clears a pending triggered start. The advance in the writing cycle still follows the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Mode code to store |
| mode_rd | output | 3 | Stored mode code |
| cfg_en | input | 1 | Global counter enable |
| cfg_dir | input | 1 | Direction, 0 up, 1 down |
| cfg_reload | input | CNT_W | Reload (wrap) value |
| cnt_load | input | 1 | Load strobe for the count |
| cnt_load_val | input | CNT_W | Value loaded by cnt_load |
| trig_in | input | 1 | Asynchronous trigger input |
| cnt_val | output | CNT_W | Current count |
| upd_pulse | output | 1 | One-cycle wrap indication |

## Verification
Two pairs of functions can land in the same cycle. A load strobe can coincide with the edge on which the counter would wrap. The bench provokes this by asserting the load while the count equals the reload value, and it requires the loaded value with no pulse, then a normal wrap on the following edge. A mode write can also coincide with a running triggered count. Here the bench requires one last advance under the old mode, then a hold, because the pending start has been cleared and the trigger stays high without a new rise.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] CODE_FREE  = 3'd0;
  localparam logic [MODE_W-1:0] CODE_GATED = 3'd5;
  localparam logic [MODE_W-1:0] CODE_EDGE  = 3'd6;

  typedef enum logic [1:0] {
    QUAL_FREE,
    QUAL_GATED,
    QUAL_EDGE,
    QUAL_HOLD
  } qual_e;

  function automatic qual_e decode_mode(input logic [MODE_W-1:0] code);
    qual_e q;
    case (code)
      CODE_FREE:  q = QUAL_FREE;
      CODE_GATED: q = QUAL_GATED;
      CODE_EDGE:  q = QUAL_EDGE;
      default:    q = QUAL_HOLD;
    endcase
    return q;
  endfunction
endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic trig_lvl,
  output logic trig_rise
);
  logic [STAGES-1:0] chain_q;
  logic              lvl_prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= trig_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev_q <= 1'b0;
    else        lvl_prev_q <= chain_q[STAGES-1];
  end

  assign trig_lvl  = chain_q[STAGES-1];
  assign trig_rise = chain_q[STAGES-1] & ~lvl_prev_q;
endmodule

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg
  import trig_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] code,
  output qual_e             qual
);
  logic [MODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  code_q <= CODE_FREE;
    else if (wr) code_q <= wdata;
  end

  assign code = code_q;
  assign qual = decode_mode(code_q);
endmodule

// File: rtl/tmr_enable_ctrl.sv
module tmr_enable_ctrl
  import trig_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  qual_e qual,
  input  logic  mode_wr,
  input  logic  cnt_en,
  input  logic  trig_lvl,
  input  logic  trig_rise,
  output logic  advance
);
  logic started_q;
  logic permit;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  started_q <= 1'b0;
    else if (!cnt_en || mode_wr)                 started_q <= 1'b0;
    else if (qual == QUAL_EDGE && trig_rise)     started_q <= 1'b1;
  end

  always_comb begin
    case (qual)
      QUAL_FREE:  permit = 1'b1;
      QUAL_GATED: permit = trig_lvl;
      QUAL_EDGE:  permit = started_q | trig_rise;
      default:    permit = 1'b0;
    endcase
  end

  assign advance = cnt_en & permit;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             dir_down,
  input  logic [CNT_W-1:0] reload,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_pulse
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stepped;
  logic             at_edge;
  logic             pulse_q;

  always_comb begin
    if (dir_down) begin
      at_edge = (cnt_q == ZERO);
      stepped = at_edge ? reload : cnt_q - STEP;
    end else begin
      at_edge = (cnt_q >= reload);
      stepped = at_edge ? ZERO : cnt_q + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= ZERO;
      pulse_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      pulse_q <= 1'b0;
    end else if (advance) begin
      cnt_q   <= stepped;
      pulse_q <= at_edge;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign count      = cnt_q;
  assign wrap_pulse = pulse_q;
endmodule

// File: rtl/trig_timer.sv
module trig_timer
  import trig_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_wdata,
  output logic [2:0]       mode_rd,
  input  logic             cfg_en,
  input  logic             cfg_dir,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic             trig_in,
  output logic [CNT_W-1:0] cnt_val,
  output logic             upd_pulse
);
  qual_e qual;
  logic  trig_lvl;
  logic  trig_rise;
  logic  advance;

  tmr_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_async(trig_in),
    .trig_lvl  (trig_lvl),
    .trig_rise (trig_rise)
  );

  tmr_mode_reg u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (mode_wr),
    .wdata(mode_wdata),
    .code (mode_rd),
    .qual (qual)
  );

  tmr_enable_ctrl u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .qual     (qual),
    .mode_wr  (mode_wr),
    .cnt_en   (cfg_en),
    .trig_lvl (trig_lvl),
    .trig_rise(trig_rise),
    .advance  (advance)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (advance),
    .dir_down  (cfg_dir),
    .reload    (cfg_reload),
    .load      (cnt_load),
    .load_val  (cnt_load_val),
    .count     (cnt_val),
    .wrap_pulse(upd_pulse)
  );
endmodule

// File: rtl/trig_timer_checker.sv
module trig_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [2:0]       mode_wdata,
  input logic [2:0]       mode_rd,
  input logic             cfg_en,
  input logic             cfg_dir,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt_load_val,
  input logic [CNT_W-1:0] cnt_val,
  input logic             upd_pulse
);
  a_r2_mode_readback: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_wr) |-> mode_rd == $past(mode_wdata));

  a_r10_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_en) && !$past(cnt_load)) |-> cnt_val == $past(cnt_val));

  a_r7_unknown_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_rd) != 3'd0 && $past(mode_rd) != 3'd5 && $past(mode_rd) != 3'd6
     && !$past(cnt_load)) |-> cnt_val == $past(cnt_val));

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_load) |-> (cnt_val == $past(cnt_load_val) && !upd_pulse));

  a_r9_up_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && !$past(cfg_dir)) |-> cnt_val == '0);
endmodule

bind trig_timer trig_timer_checker #(.CNT_W(CNT_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_wr     (mode_wr),
  .mode_wdata  (mode_wdata),
  .mode_rd     (mode_rd),
  .cfg_en      (cfg_en),
  .cfg_dir     (cfg_dir),
  .cnt_load    (cnt_load),
  .cnt_load_val(cnt_load_val),
  .cnt_val     (cnt_val),
  .upd_pulse   (upd_pulse)
);

// File: tb/test_trig_timer.sv
`timescale 1ns/1ps
module test_trig_timer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_wr = 1'b0;
  logic [2:0]       mode_wdata = '0;
  logic [2:0]       mode_rd;
  logic             cfg_en = 1'b0;
  logic             cfg_dir = 1'b0;
  logic [CNT_W-1:0] cfg_reload = 16'd100;
  logic             cnt_load = 1'b0;
  logic [CNT_W-1:0] cnt_load_val = '0;
  logic             trig_in = 1'b0;
  logic [CNT_W-1:0] cnt_val;
  logic             upd_pulse;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  trig_timer #(.CNT_W(CNT_W)) i_trig_timer (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .mode_rd(mode_rd), .cfg_en(cfg_en), .cfg_dir(cfg_dir), .cfg_reload(cfg_reload),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .trig_in(trig_in),
    .cnt_val(cnt_val), .upd_pulse(upd_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int v);
    cnt_load = 1'b1; cnt_load_val = CNT_W'(v);
    tick(1);
    cnt_load = 1'b0;
  endtask

  task automatic set_mode(input int c);
    mode_wr = 1'b1; mode_wdata = 3'(c);
    tick(1);
    mode_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count", int'(cnt_val), 0);
    check("R1 mode", int'(mode_rd), 0);
    check("R1 pulse", int'(upd_pulse), 0);
  endtask

  task automatic t_readback;
    set_mode(3); check("R2 code 3", int'(mode_rd), 3);
    set_mode(7); check("R2 code 7", int'(mode_rd), 7);
    set_mode(0); check("R2 code 0", int'(mode_rd), 0);
  endtask

  task automatic t_free_dir;
    cfg_en = 1'b0; cfg_reload = 16'd100;
    load(10); check("R11 preset", int'(cnt_val), 10);
    cfg_en = 1'b1; tick(5); check("R3 free up", int'(cnt_val), 15);
    cfg_dir = 1'b1; tick(3); check("R8 down", int'(cnt_val), 12);
    cfg_dir = 1'b0;
  endtask

  task automatic t_off;
    cfg_en = 1'b0; tick(4); check("R10 free off", int'(cnt_val), 12);
    set_mode(5); trig_in = 1'b1; tick(6); check("R10 gated off", int'(cnt_val), 12);
    trig_in = 1'b0; tick(3);
  endtask

  task automatic t_hold;
    set_mode(2); cfg_en = 1'b1; tick(5);
    check("R7 hold count", int'(cnt_val), 12);
    check("R7 code kept", int'(mode_rd), 2);
    cfg_en = 1'b0;
  endtask

  task automatic t_gated;
    set_mode(5); load(0); cfg_en = 1'b1;
    tick(4); check("R4 low holds", int'(cnt_val), 0);
    trig_in = 1'b1;
    tick(2); check("R4 latency", int'(cnt_val), 0);
    tick(1); check("R4 first step", int'(cnt_val), 1);
    tick(4); check("R4 high runs", int'(cnt_val), 5);
    trig_in = 1'b0;
    tick(2); check("R4 fall latency", int'(cnt_val), 7);
    tick(5); check("R4 low holds again", int'(cnt_val), 7);
    cfg_en = 1'b0;
  endtask

  task automatic t_triggered;
    set_mode(6); load(0); cfg_en = 1'b1;
    tick(4); check("R5 waits", int'(cnt_val), 0);
    trig_in = 1'b1;
    tick(2); check("R5 latency", int'(cnt_val), 0);
    tick(1); check("R5 start", int'(cnt_val), 1);
    trig_in = 1'b0;
    tick(5); check("R5 keeps running", int'(cnt_val), 6);
    trig_in = 1'b1;
    tick(5); check("R5 second edge no effect", int'(cnt_val), 11);
  endtask

  task automatic t_rearm;
    cfg_en = 1'b0; tick(2); check("R6 stop", int'(cnt_val), 11);
    cfg_en = 1'b1; tick(4); check("R6 needs new rise", int'(cnt_val), 11);
    trig_in = 1'b0; tick(3); check("R6 still idle", int'(cnt_val), 11);
    trig_in = 1'b1; tick(3); check("R6 restart", int'(cnt_val), 12);
    tick(2); check("R6 running", int'(cnt_val), 14);
  endtask

  task automatic t_mode_clear;
    set_mode(6); check("R12 old mode last step", int'(cnt_val), 15);
    tick(3); check("R12 start cleared", int'(cnt_val), 15);
    cfg_en = 1'b0; trig_in = 1'b0;
  endtask

  task automatic t_wrap;
    set_mode(0); cfg_reload = 16'd3; cfg_dir = 1'b0;
    load(2); cfg_en = 1'b1;
    tick(1); check("R9 up to reload", int'(cnt_val), 3); check("R9 no pulse", int'(upd_pulse), 0);
    tick(1); check("R9 up wrap", int'(cnt_val), 0); check("R9 up pulse", int'(upd_pulse), 1);
    tick(1); check("R9 after wrap", int'(cnt_val), 1); check("R9 pulse one cycle", int'(upd_pulse), 0);
    cfg_en = 1'b0; cfg_dir = 1'b1; load(1); cfg_en = 1'b1;
    tick(1); check("R9 down to zero", int'(cnt_val), 0);
    tick(1); check("R9 down wrap", int'(cnt_val), 3); check("R9 down pulse", int'(upd_pulse), 1);
    tick(1); check("R9 down after", int'(cnt_val), 2); check("R9 down pulse drop", int'(upd_pulse), 0);
    cfg_en = 1'b0; cfg_dir = 1'b0;
  endtask

  task automatic t_collide;
    load(2); cfg_en = 1'b1;
    tick(1); check("R11 at reload", int'(cnt_val), 3);
    load(7);
    check("R11 load wins", int'(cnt_val), 7); check("R11 no pulse", int'(upd_pulse), 0);
    tick(1); check("R9 wrap above reload", int'(cnt_val), 0); check("R9 pulse above reload", int'(upd_pulse), 1);
    cfg_en = 1'b0;
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset();
    t_readback();
    t_free_dir();
    t_off();
    t_hold();
    t_gated();
    t_triggered();
    t_rearm();
    t_mode_clear();
    t_wrap();
    t_collide();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule